// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block gates a group of clock outputs derived from one source clock. An active-low stop request arrives asynchronously and passes through a synchronizer into the clock domain; while it is low, the stoppable outputs are held low. Each output also has its own enable bit from the configuration registers, and a cleared bit holds that output low regardless of the stop request. Outputs marked in a free-running mask ignore the stop request but still obey their enable bit.

Every gating decision is taken by a falling-edge register feeding an AND gate. Gating therefore only changes while the source clock is low, so an output never shows a runt pulse. It stops in the low state and its first high phase after a restart is full width. The synchronizer depth sets the on and off latency. For a processor clock group, the defaults give two cycles each and require the request to stay high for 100 cycles between stops. For a peripheral group, set a single stage and a minimum of 10 cycles. A stop that comes sooner than that minimum is still carried out, and the block raises a sticky violation flag.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_ni is low, every gclk_o bit is low and viol_o is 0.
- R2: The stop request is taken through SYNC_STAGES rising-edge flops. If stop_ni is low at rising edge P, a stoppable output produces no high pulse at rising edge P+SYNC_STAGES, while rising edges up to P+SYNC_STAGES-1 still depend on earlier samples.
- R3: If stop_ni is high at rising edge P and the output is enabled, the output follows the source clock for the whole high phase beginning at rising edge P+SYNC_STAGES.
- R4: A stopped output stays low in both clock phases for as long as the synchronized request stays low.
- R5: en_i[i] is sampled on the falling edge of clk_i. A 0 holds gclk_o[i] low from the next rising edge on, and a 1 lets it run from the next rising edge on (subject to R2).
- R6: An output whose FREE_MASK bit is 1 ignores stop_ni entirely and is gated only by its enable bit. The default mask makes bit 0 free-running.
- R7: The block counts consecutive cycles with the synchronized request high, saturating at MIN_ON. If that run ends with a count from 1 to MIN_ON-1, viol_o rises at the rising edge where the synchronized low is first seen. The stop is still carried out.
- R8: Once viol_o is 1, only reset clears it.
- R9: gclk_o[i] is never high while clk_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock of the group |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous active-low stop request |
| en_i | input | N_OUT | Per-output enable from the registers, 1 = running |
| gclk_o | output | N_OUT | Gated clock outputs |
| viol_o | output | 1 | Sticky flag: stop came before the minimum enabled time |

## Verification
Two decisions can land on the same falling edge: an enable bit can change just as a synchronized stop or restart reaches the gate. In that case the resulting pulse train must match the AND of both decisions, with no partial pulse. Separately, the violation flag can rise on the same edge that a short request ends, while the stop itself still takes effect. The bench provokes both cases with directed and random stimulus. It changes enable bits and the stop request in the same cycle, and it uses short random high runs of the request. A cycle-level model of the synchronizer and run-length counter judges each output in its high and low phase, and judges the flag on every cycle.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= req_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], req_ni};
      end
    end
  endgenerate

  assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/clk_stop_minon.sv
module clk_stop_minon #(
  parameter int unsigned MIN_ON = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic viol_o
);
  localparam int unsigned CW = clk_stop_pkg::cnt_width(MIN_ON);
  localparam logic [CW-1:0] LIM = CW'(MIN_ON);

  logic [CW-1:0] cnt_q;
  logic          viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else if (run_i) begin
      if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end else begin
      // run just ended short of the minimum
      if (cnt_q != '0 && cnt_q < LIM) viol_q <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_i,
  output logic open_o,
  output logic gclk_o
);
  logic open_q;

  // updated only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= pass_i;
  end

  assign open_o = open_q;
  assign gclk_o = clk_i & open_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned          N_OUT       = 4,
  parameter logic [N_OUT-1:0]     FREE_MASK   = 4'b0001,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter int unsigned          MIN_ON      = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  input  logic [N_OUT-1:0] en_i,
  output logic [N_OUT-1:0] gclk_o,
  output logic             viol_o
);
  logic             run_s;
  logic [N_OUT-1:0] pass_w;
  logic [N_OUT-1:0] gate_open;

  clk_stop_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_ni(stop_ni),
    .run_o (run_s)
  );

  clk_stop_minon #(.MIN_ON(MIN_ON)) i_minon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_s),
    .viol_o(viol_o)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    if (FREE_MASK[i]) begin : g_free
      assign pass_w[i] = en_i[i];
    end else begin : g_stop
      assign pass_w[i] = en_i[i] & run_s;
    end
    clk_gate_cell i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pass_i(pass_w[i]),
      .open_o(gate_open[i]),
      .gclk_o(gclk_o[i])
    );
  end
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned      N_OUT     = 4,
  parameter logic [N_OUT-1:0] FREE_MASK = 4'b0001
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_OUT-1:0] en_i,
  input logic             run_i,
  input logic [N_OUT-1:0] gate_i,
  input logic             viol_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_closed_r1: assert (gate_i == '0 && !viol_i);
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_p
    p_enable_low_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !en_i[i] |=> !gate_i[i]);
    if (FREE_MASK[i]) begin : g_f
      p_free_runs_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        en_i[i] |=> gate_i[i]);
    end else begin : g_s
      p_stop_holds_low_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !run_i |=> !gate_i[i]);
      p_restart_opens_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (run_i && en_i[i]) |=> gate_i[i]);
    end
  end

  p_viol_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> viol_i);

  p_viol_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_i) |-> (!$past(run_i) && $past(run_i, 2)));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_OUT(N_OUT), .FREE_MASK(FREE_MASK)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .run_i (run_s),
  .gate_i(gate_open),
  .viol_i(viol_o)
);

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
  localparam int unsigned N    = 4;
  localparam logic [N-1:0] FREE = 4'b0001;
  localparam int unsigned S    = 2;
  localparam int unsigned MIN  = 100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_n = 1'b1;
  logic [N-1:0] en = '1;
  logic [N-1:0] gclk;
  logic         viol;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_stop_gate #(.N_OUT(N), .FREE_MASK(FREE), .SYNC_STAGES(S), .MIN_ON(MIN)) i_clk_stop_gate (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .en_i(en), .gclk_o(gclk), .viol_o(viol)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // expected gate for one output, from the requirements
  function automatic logic exp_bit(input int i, input logic e, input logic run);
    return e & (FREE[i] | run);
  endfunction

  function automatic string tag_of(input int i, input logic e, input logic run);
    if (!e)      return "R5";
    if (FREE[i]) return "R6";
    if (!run)    return "R2 R4";
    return "R3";
  endfunction

  // cycle model: hist[S-1] is the request value seen S rising edges ago
  logic [S-1:0] hist;
  int           run_len;
  logic         viol_exp;
  logic [N-1:0] exp_v;

  always begin
    @(posedge clk);
    #1;
    if (!rst_n) begin
      hist = '0; run_len = 0; viol_exp = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) exp_v[i] = exp_bit(i, en[i], hist[S-1]);
      if (hist[S-1]) begin
        if (run_len < MIN) run_len++;
      end else begin
        if (run_len > 0 && run_len < MIN) viol_exp = 1'b1;
        run_len = 0;
      end
      for (int i = 0; i < N; i++)
        chk(gclk[i] === exp_v[i], tag_of(i, en[i], hist[S-1]), gclk[i], exp_v[i]);
      chk(viol === viol_exp, viol_exp ? "R7" : "R7 R8", viol, viol_exp);
      hist = (hist << 1) | S'(stop_n);
      #2;
      if (rst_n) begin
        // still high phase: pulse must be full width
        for (int i = 0; i < N; i++)
          chk(gclk[i] === exp_v[i], "R3 R9", gclk[i], exp_v[i]);
      end
      #2;
      chk(gclk === '0, "R9", gclk, 0);
    end
  end

  task automatic set_in(input logic s, input logic [N-1:0] e);
    @(posedge clk); #2; stop_n = s; en = e;
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1C));
    // R1: reset state with everything requesting to run
    repeat (4) begin
      @(posedge clk); #1;
      chk(gclk === '0, "R1", gclk, 0);
      chk(viol === 1'b0, "R1", viol, 0);
      #2;
      chk(gclk === '0, "R1", gclk, 0);
    end
    @(posedge clk); #2; rst_n = 1'b1;
    hold(MIN + 20);

    // directed stop and restart, off/on latency (R2 R3 R4)
    set_in(1'b0, '1); hold(12);
    set_in(1'b1, '1); hold(MIN + 10);
    chk(viol === 1'b0, "R7", viol, 0);

    // enable changes alone, then same cycle as a stop edge (R5 R6)
    set_in(1'b1, 4'b0101); hold(6);
    set_in(1'b0, 4'b1110); hold(8);
    set_in(1'b1, 4'b0011); hold(MIN + 5);
    set_in(1'b0, 4'b0000); hold(5);
    set_in(1'b0, 4'b1111); hold(5);
    set_in(1'b1, 4'b1111); hold(MIN + 5);

    // short high run between stops: honoured, flag raised (R7)
    set_in(1'b0, '1); hold(6);
    set_in(1'b1, '1); hold(4);
    set_in(1'b0, '1); hold(S + 4);
    chk(viol === 1'b1, "R7", viol, 1);
    chk(gclk[3:1] === 3'b000, "R7 R4", gclk[3:1], 0);
    set_in(1'b1, '1); hold(MIN + 20);
    chk(viol === 1'b1, "R8", viol, 1);

    // reset clears the flag (R8 R1)
    @(posedge clk); #2; rst_n = 1'b0;
    @(posedge clk); #2;
    chk(viol === 1'b0, "R8", viol, 0);
    chk(gclk === '0, "R1", gclk, 0);
    rst_n = 1'b1;
    hold(MIN + 10);

    // random segments
    for (int k = 0; k < 60; k++) begin
      set_in(1'($urandom_range(0, 3) != 0), N'($urandom));
      hold($urandom_range(1, 140));
    end
    set_in(1'b1, '1); hold(10);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule